// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit holds two 16-bit data pointers for an 8052-style core. One is the standard pointer and the other is an alternate pointer. A one-bit select register decides which pointer the core's pointer operations act on. Those operations are the 16-bit immediate load, the 16-bit increment and the external data memory address used by MOVX reads and writes. Code that never touches the select register sees only the standard pointer, so legacy programs behave as before.

Both pointers and the select register can be reached through a byte-wide SFR port. Writing a pointer byte by its SFR address reaches that pointer whatever the select bit holds. A block copy can keep the source address in one pointer and the destination in the other. It then switches between them with the select increment and decrement commands, and never has to save or reload the pointer bytes.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset both pointers are 0x0000, the select bit is 0, `ptr_sel` is 0 and `xaddr` is 0x0000.
- R2: SFR byte map: 82h is the standard pointer's low byte, 83h is its high byte, 84h is the alternate pointer's high byte, 85h is the alternate pointer's low byte and 86h is the select register. `sfr_hit` is 1 only for these five addresses. Any other address reads 0x00.
- R3: Only bit 0 of the select register exists. An SFR write to 86h loads it from `sfr_wdata[0]`, and a read of 86h returns bits 7:1 as 0.
- R4: `xaddr` always shows the selected pointer (standard when `ptr_sel`=0, alternate when 1). `ptr_sel` shows the select bit.
- R5: `cmd_load` writes `cmd_imm` into the pointer selected in that cycle, visible on the next clock. The other pointer is unchanged.
- R6: `cmd_inc` adds 1 to the selected pointer across all 16 bits, with carry from the low byte into the high byte. 0xFFFF wraps to 0x0000. The other pointer is unchanged.
- R7: `cmd_sel_inc` or `cmd_sel_dec` alone toggles the select bit. Both together leave it unchanged. An SFR write to 86h in the same cycle takes priority over both.
- R8: SFR reads and writes of 82h to 85h reach the addressed pointer byte regardless of the select bit.
- R9: When an SFR write hits a byte of a pointer in the same cycle as a load or increment of that pointer, the written byte takes `sfr_wdata`, the other byte keeps its old value, and the command is dropped.
- R10: When `cmd_load` and `cmd_inc` are asserted together, the load wins.
- R11: An SFR write to an address outside 82h to 86h changes no pointer and not the select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational from `sfr_addr`) |
| sfr_hit | output | 1 | `sfr_addr` decodes to a register of this unit |
| cmd_load | input | 1 | Load the selected pointer with `cmd_imm` |
| cmd_imm | input | 16 | Immediate value for the load |
| cmd_inc | input | 1 | Increment the selected pointer |
| cmd_sel_inc | input | 1 | Increment the select register |
| cmd_sel_dec | input | 1 | Decrement the select register |
| xaddr | output | 16 | External data memory address (selected pointer) |
| ptr_sel | output | 1 | Current select bit |

## Verification
Four behaviours are checked on every cycle by the assertions. An uncontested load makes `xaddr` equal the immediate on the next cycle, and an uncontested increment makes it step by one. A lone select command flips `ptr_sel`, and with no command and no write both `ptr_sel` and `xaddr` hold. Other behaviour only the bench's scenarios can show: the SFR byte placement and reads of the unselected pointer, the byte-merge rule when a write collides with an increment, the wrap from 0xFFFF, and the write to 86h winning over a select command.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  typedef enum logic [2:0] {
    FLD_NONE  = 3'd0,
    FLD_P0_LO = 3'd1,
    FLD_P0_HI = 3'd2,
    FLD_P1_LO = 3'd3,
    FLD_P1_HI = 3'd4,
    FLD_SEL   = 3'd5
  } sfr_fld_e;

  // 16-bit pointer step with natural wrap
  function automatic logic [15:0] ptr_incr(input logic [15:0] p);
    return p + 16'd1;
  endfunction

  // replace one byte of a pointer, keep the other
  function automatic logic [15:0] byte_merge(input logic [15:0] p,
                                             input logic        hi,
                                             input logic [7:0]  b);
    return hi ? {b, p[7:0]} : {p[15:8], b};
  endfunction

endpackage

// File: rtl/dptr_sfr_decode.sv
module dptr_sfr_decode
  import dptr_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  A_P0_LO = 8'h82,
  parameter logic [7:0]  A_P0_HI = 8'h83,
  parameter logic [7:0]  A_P1_HI = 8'h84,
  parameter logic [7:0]  A_P1_LO = 8'h85,
  parameter logic [7:0]  A_SEL   = 8'h86
) (
  input  logic [ADDR_W-1:0] addr,
  output sfr_fld_e          fld,
  output logic              hit
);
  always_comb begin
    case (addr)
      A_P0_LO: fld = FLD_P0_LO;
      A_P0_HI: fld = FLD_P0_HI;
      A_P1_HI: fld = FLD_P1_HI;
      A_P1_LO: fld = FLD_P1_LO;
      A_SEL:   fld = FLD_SEL;
      default: fld = FLD_NONE;
    endcase
  end
  assign hit = (fld != FLD_NONE);
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic             ld,
  input  logic [PTR_W-1:0] imm,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  logic             sfr_touch;
  logic [PTR_W-1:0] ptr_nxt;

  assign sfr_touch = wr_lo | wr_hi;

  always_comb begin
    ptr_nxt = ptr;
    if (sfr_touch)  ptr_nxt = byte_merge(ptr, wr_hi, wdata);
    else if (ld)    ptr_nxt = imm;
    else if (inc)   ptr_nxt = ptr_incr(ptr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end
endmodule

// File: rtl/dptr_select.sv
module dptr_select (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  input  logic step_up,
  input  logic step_dn,
  output logic sel
);
  logic flip;
  assign flip = step_up ^ step_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= 1'b0;
    else if (wr)   sel <= wbit;
    else if (flip) sel <= ~sel;
  end
endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter int         PTR_W  = 16,
  parameter int         ADDR_W = 8,
  parameter logic [7:0] A_P0_LO = 8'h82,
  parameter logic [7:0] A_P0_HI = 8'h83,
  parameter logic [7:0] A_P1_HI = 8'h84,
  parameter logic [7:0] A_P1_LO = 8'h85,
  parameter logic [7:0] A_SEL   = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  output logic              sfr_hit,
  input  logic              cmd_load,
  input  logic [PTR_W-1:0]  cmd_imm,
  input  logic              cmd_inc,
  input  logic              cmd_sel_inc,
  input  logic              cmd_sel_dec,
  output logic [PTR_W-1:0]  xaddr,
  output logic              ptr_sel
);
  localparam int NPTR = 2;

  sfr_fld_e         fld;
  logic [PTR_W-1:0] ptr [NPTR];
  logic [NPTR-1:0]  wr_lo, wr_hi, ld_hit, inc_hit;
  logic             sel_wr;

  dptr_sfr_decode #(
    .ADDR_W(ADDR_W), .A_P0_LO(A_P0_LO), .A_P0_HI(A_P0_HI),
    .A_P1_HI(A_P1_HI), .A_P1_LO(A_P1_LO), .A_SEL(A_SEL)
  ) u_dec (
    .addr(sfr_addr), .fld(fld), .hit(sfr_hit)
  );

  assign wr_lo[0] = sfr_we && (fld == FLD_P0_LO);
  assign wr_hi[0] = sfr_we && (fld == FLD_P0_HI);
  assign wr_lo[1] = sfr_we && (fld == FLD_P1_LO);
  assign wr_hi[1] = sfr_we && (fld == FLD_P1_HI);
  assign sel_wr   = sfr_we && (fld == FLD_SEL);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    assign ld_hit[g]  = cmd_load && (ptr_sel == g[0]);
    assign inc_hit[g] = cmd_inc  && (ptr_sel == g[0]);
    dptr_reg #(.PTR_W(PTR_W)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]), .wdata(sfr_wdata),
      .ld(ld_hit[g]), .imm(cmd_imm), .inc(inc_hit[g]),
      .ptr(ptr[g])
    );
  end

  dptr_select u_sel (
    .clk(clk), .rst_n(rst_n),
    .wr(sel_wr), .wbit(sfr_wdata[0]),
    .step_up(cmd_sel_inc), .step_dn(cmd_sel_dec),
    .sel(ptr_sel)
  );

  assign xaddr = ptr_sel ? ptr[1] : ptr[0];

  always_comb begin
    case (fld)
      FLD_P0_LO: sfr_rdata = ptr[0][7:0];
      FLD_P0_HI: sfr_rdata = ptr[0][PTR_W-1:8];
      FLD_P1_LO: sfr_rdata = ptr[1][7:0];
      FLD_P1_HI: sfr_rdata = ptr[1][PTR_W-1:8];
      FLD_SEL:   sfr_rdata = {7'd0, ptr_sel};
      default:   sfr_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dual_dptr_chk.sv
module dual_dptr_chk #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 8,
  parameter logic [7:0] A_SEL = 8'h86
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_we,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [7:0]        sfr_rdata,
  input logic              cmd_load,
  input logic [PTR_W-1:0]  cmd_imm,
  input logic              cmd_inc,
  input logic              cmd_sel_inc,
  input logic              cmd_sel_dec,
  input logic [PTR_W-1:0]  xaddr,
  input logic              ptr_sel,
  input logic              sel_wr
);
  logic quiet_sel;
  assign quiet_sel = !cmd_sel_inc && !cmd_sel_dec;

  a_r5_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !sfr_we && quiet_sel) |=> (xaddr == $past(cmd_imm)));

  a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inc && !cmd_load && !sfr_we && quiet_sel) |=> (xaddr == $past(xaddr) + 1'b1));

  a_r7_sel_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_sel_inc ^ cmd_sel_dec) && !sel_wr) |=> (ptr_sel != $past(ptr_sel)));

  a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_sel && !sfr_we) |=> $stable(ptr_sel));

  a_r4_xaddr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_sel && !sfr_we && !cmd_load && !cmd_inc) |=> $stable(xaddr));

  a_r3_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == A_SEL) |-> (sfr_rdata[7:1] == 7'd0));
endmodule

bind dual_dptr_unit dual_dptr_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .A_SEL(A_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
  .sfr_rdata(sfr_rdata), .cmd_load(cmd_load), .cmd_imm(cmd_imm),
  .cmd_inc(cmd_inc), .cmd_sel_inc(cmd_sel_inc), .cmd_sel_dec(cmd_sel_dec),
  .xaddr(xaddr), .ptr_sel(ptr_sel), .sel_wr(sel_wr)
);

// File: tb/dual_dptr_unit_tb.sv
module dual_dptr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        sfr_hit;
  logic        cmd_load = 1'b0;
  logic [15:0] cmd_imm = 16'h0000;
  logic        cmd_inc = 1'b0;
  logic        cmd_sel_inc = 1'b0;
  logic        cmd_sel_dec = 1'b0;
  logic [15:0] xaddr;
  logic        ptr_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  dual_dptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
    .cmd_load(cmd_load), .cmd_imm(cmd_imm), .cmd_inc(cmd_inc),
    .cmd_sel_inc(cmd_sel_inc), .cmd_sel_dec(cmd_sel_dec),
    .xaddr(xaddr), .ptr_sel(ptr_sel)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [7:0]  wd;
    logic        ld;
    logic [15:0] imm;
    logic        inc;
    logic        si;
    logic        sd;
    logic [15:0] ex_addr;
    logic        ex_sel;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 8'h00, 1'b1, 16'h2000, 1'b0, 1'b0, 1'b0, 16'h2000, 1'b0}, // R5 load standard
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1}, // R7 sel up
    '{1'b0, 8'h00, 8'h00, 1'b1, 16'h3500, 1'b0, 1'b0, 1'b0, 16'h3500, 1'b1}, // R5 load alternate
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h2000, 1'b0}, // R4/R7 sel down
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h2001, 1'b0}, // R6 inc
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h3500, 1'b1}, // R6 inc on old sel
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h3501, 1'b1}, // R6 inc alternate
    '{1'b0, 8'h00, 8'h00, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1}, // R5
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1}, // R6 wrap
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0000, 1'b1}, // R7 both cancel
    '{1'b1, 8'h85, 8'h12, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0012, 1'b1}, // R9 write beats inc
    '{1'b1, 8'h83, 8'hAB, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0012, 1'b1}, // R8 unselected write
    '{1'b0, 8'h00, 8'h00, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b0, 16'h1234, 1'b1}, // R10 load beats inc
    '{1'b1, 8'h86, 8'hFF, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h1234, 1'b1}, // R7 write beats sel up
    '{1'b1, 8'h86, 8'h02, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hAB02, 1'b0}, // R3 bit0 only
    '{1'b1, 8'h90, 8'h55, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hAB02, 1'b0}, // R11 foreign addr
    '{1'b1, 8'h82, 8'hFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'hABFF, 1'b0}, // R2 low byte
    '{1'b0, 8'h00, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'hAC00, 1'b0}  // R6 carry
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sfr_we = 1'b0; cmd_load = 1'b0; cmd_inc = 1'b0;
    cmd_sel_inc = 1'b0; cmd_sel_dec = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a,
                    input logic [7:0] exp_d, input logic exp_hit);
    sfr_addr = a;
    #1;
    check(req, {8'h00, sfr_rdata}, {8'h00, exp_d});
    check(req, {15'd0, sfr_hit}, {15'd0, exp_hit});
  endtask

  initial begin : watchdog
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", xaddr, 16'h0000);
    check("R1", {15'd0, ptr_sel}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      sfr_we = VECS[i].we; sfr_addr = VECS[i].addr; sfr_wdata = VECS[i].wd;
      cmd_load = VECS[i].ld; cmd_imm = VECS[i].imm; cmd_inc = VECS[i].inc;
      cmd_sel_inc = VECS[i].si; cmd_sel_dec = VECS[i].sd;
      @(negedge clk);
      idle();
      check($sformatf("R4 vec %0d addr", i), xaddr, VECS[i].ex_addr);
      check($sformatf("R4 vec %0d sel", i), {15'd0, ptr_sel}, {15'd0, VECS[i].ex_sel});
    end

    // R2/R8 direct reads: standard = AC00, alternate = 1234, select = 0
    rd("R2 p0 lo", 8'h82, 8'h00, 1'b1);
    rd("R8 p0 hi", 8'h83, 8'hAC, 1'b1);
    rd("R8 p1 hi", 8'h84, 8'h12, 1'b1);
    rd("R8 p1 lo", 8'h85, 8'h34, 1'b1);
    rd("R3 sel",   8'h86, 8'h00, 1'b1);
    rd("R2 miss",  8'h81, 8'h00, 1'b0);
    // R3 upper select bits read 0 after writing all ones
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = 8'h86; sfr_wdata = 8'hFF;
    @(negedge clk);
    idle();
    rd("R3 sel hi zero", 8'h86, 8'h01, 1'b1);
    check("R4 alt shown", xaddr, 16'h1234);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    check("R1 xaddr", xaddr, 16'h0000);
    check("R1 sel", {15'd0, ptr_sel}, 16'd0);
    rd("R1 p1 hi", 8'h84, 8'h00, 1'b1);
    rd("R1 p0 hi", 8'h83, 8'h00, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule